// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Output

This block is a 16-bit timer/counter with a one-byte control register that picks how it runs. In auto-reload mode the counter restarts from a reload register each time it wraps. In capture mode a falling edge on an external trigger pin copies the running count into a capture register. In serial-clock mode its wrap pulses serve as the receive and/or transmit baud tick of a serial port.

The count source is either a system clock tick or falling edges on an external count pin. Both pins pass through a synchronizer before any edge is detected. Software reaches the control byte, a direction-option byte, the counter, the reload register and the capture register through a byte-wide write/read port.

The interrupt request combines two flags. The overflow flag is set on a wrap while the serial port is not being clocked. The trigger flag is set on a trigger-caused capture or reload. The trigger flag is kept out of the request while the up/down option bit is set.

Top module: `cr_timer`

## Requirements
- R1: After reset every register reads 0x00 at every address, irq_o is 0, and both pin synchronizers hold 0, so a pin that is high at reset produces no falling edge.
- R2: While the run bit (control bit 0) is 0, the counter holds its value; it advances only when the run bit is 1.
- R3: Control bit 1 selects the count source: 0 counts cycles with tick_i high; 1 counts synchronized falling edges of cnt_pin_i and ignores tick_i.
- R4: A count step taken at 0xFFFF is an overflow. It loads the reload register when control bit 2 (capture select) is 0 or when the timer clocks the serial port, and otherwise wraps to 0x0000.
- R5: Control bit 6 (overflow flag) is set by an overflow only while control bits 4 and 5 are both 0. It is cleared only by a software write of 0 to that bit; a hardware set in the same cycle as that write wins.
- R6: With control bit 3 (trigger enable) at 1, capture select at 0 and no serial clocking, a trigger falling edge loads the counter from the reload register and sets control bit 7 (trigger flag). With bit 3 at 0 the edge changes nothing.
- R7: With trigger enable and capture select both 1 and no serial clocking, a trigger falling edge copies the counter into the capture register and sets the trigger flag; counting is not disturbed.
- R8: While control bit 4 (receive clock select) or bit 5 (transmit clock select) is 1, capture select is ignored for overflow handling, and trigger edges cause no capture, no reload and no trigger flag.
- R9: rx_baud_o is a one-cycle pulse in the cycle after each overflow while bit 4 is 1, and follows alt_rx_tick_i when bit 4 is 0. tx_baud_o behaves the same with bit 5 and alt_tx_tick_i.
- R10: irq_o is 1 exactly when the overflow flag is 1, or the trigger flag is 1 while the up/down option bit (bit 0 at address 1) is 0.
- R11: A pin sampled low at rising edge k after being sampled high at edge k-1 takes effect at edge k+2. A pin held low causes one event only.
- R12: Address map: 0 control, 1 option, 2/3 counter low/high, 4/5 reload low/high, 6/7 capture low/high (read-only). Readback is combinational from addr_i. A write is applied at the clock edge, and a counter byte write wins over the hardware update of that byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Internal count tick (timer source) |
| cnt_pin_i | input | 1 | External count pin, falling edges counted |
| trig_pin_i | input | 1 | External trigger pin, falling edges used |
| alt_rx_tick_i | input | 1 | Receive baud tick from another timer |
| alt_tx_tick_i | input | 1 | Transmit baud tick from another timer |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register byte address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register readback at addr_i |
| irq_o | output | 1 | Interrupt request |
| rx_baud_o | output | 1 | Receive baud tick |
| tx_baud_o | output | 1 | Transmit baud tick |

## Verification
Register writes, count steps, reloads, captures and flag sets all land on the rising edge that samples the stimulus, so they are visible one cycle later. The exception is a pin event, which is due two edges after the first low sample. Baud pulses from an overflow appear in the cycle that follows the overflow edge. The bench drives inputs on the falling edge, advances a behavioural model on the rising edge, and compares every output shortly after the next falling edge. Directed sequences add fixed expected values at known cycle offsets, including the exact cycle in which a trigger edge first shows in the flag.

// File: rtl/crt_pkg.sv
package crt_pkg;

   // control byte, most significant field first
   typedef struct packed {
      logic ext_flag;   // 7
      logic ovf_flag;   // 6
      logic tx_sel;     // 5
      logic rx_sel;     // 4
      logic ext_en;     // 3
      logic cap_sel;    // 2
      logic src_pin;    // 1
      logic run;        // 0
   } ctrl_t;

   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_MODE = 1;
   localparam int unsigned REG_CNT  = 2;

endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("crt_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign fall_o = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/crt_counter.sv
module crt_counter #(
   parameter int unsigned W = 16,
   localparam int unsigned NB = W / 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          inc_i,
   input  logic          trig_load_i,
   input  logic          trig_cap_i,
   input  logic          ovf_load_i,
   input  logic [NB-1:0] cnt_we_i,
   input  logic [NB-1:0] rld_we_i,
   input  logic [7:0]    wbyte_i,
   output logic [W-1:0]  cnt_o,
   output logic [W-1:0]  rld_o,
   output logic [W-1:0]  cap_o,
   output logic          ovf_o
);

   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   logic [W-1:0] cnt_q, rld_q, cap_q;
   logic [W-1:0] cnt_d, rld_d, wrap_val;
   logic         at_max;

   assign at_max   = (cnt_q == CNT_MAX);
   assign ovf_o    = inc_i & at_max;
   assign wrap_val = ovf_load_i ? rld_q : '0;

   always_comb begin
      cnt_d = cnt_q;
      rld_d = rld_q;
      if (trig_load_i)
         cnt_d = rld_q;
      else if (inc_i)
         cnt_d = at_max ? wrap_val : cnt_q + W'(1);
      for (int b = 0; b < NB; b++) begin
         if (cnt_we_i[b]) cnt_d[b*8 +: 8] = wbyte_i;
         if (rld_we_i[b]) rld_d[b*8 +: 8] = wbyte_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         rld_q <= '0;
         cap_q <= '0;
      end else begin
         cnt_q <= cnt_d;
         rld_q <= rld_d;
         if (trig_cap_i) cap_q <= cnt_q;
      end
   end

   assign cnt_o = cnt_q;
   assign rld_o = rld_q;
   assign cap_o = cap_q;

endmodule

// File: rtl/crt_ctrl.sv
module crt_ctrl
   import crt_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       ctrl_we_i,
   input  logic       mode_we_i,
   input  logic [7:0] wbyte_i,
   input  logic       set_ovf_i,
   input  logic       set_ext_i,
   output ctrl_t      ctrl_o,
   output logic       ud_o,
   output logic       irq_o
);

   ctrl_t ctrl_q, ctrl_d;
   logic  ud_q;

   always_comb begin
      ctrl_d = ctrl_q;
      if (ctrl_we_i) ctrl_d = ctrl_t'(wbyte_i);
      if (set_ovf_i) ctrl_d.ovf_flag = 1'b1;
      if (set_ext_i) ctrl_d.ext_flag = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
         ud_q   <= 1'b0;
      end else begin
         ctrl_q <= ctrl_d;
         if (mode_we_i) ud_q <= wbyte_i[0];
      end
   end

   assign ctrl_o = ctrl_q;
   assign ud_o   = ud_q;
   assign irq_o  = ctrl_q.ovf_flag | (ctrl_q.ext_flag & ~ud_q);

endmodule

// File: rtl/cr_timer.sv
module cr_timer
   import crt_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NB         = CNT_W / 8,
   localparam int unsigned ADDR_W     = $clog2(REG_CNT + 3 * NB)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              cnt_pin_i,
   input  logic              trig_pin_i,
   input  logic              alt_rx_tick_i,
   input  logic              alt_tx_tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o,
   output logic              irq_o,
   output logic              rx_baud_o,
   output logic              tx_baud_o
);

   localparam int unsigned RLD_BASE = REG_CNT + NB;
   localparam int unsigned CAP_BASE = REG_CNT + 2 * NB;

   if (CNT_W < 8 || CNT_W % 8 != 0) begin : g_bad_width
      $error("cr_timer: CNT_W must be a positive multiple of 8");
   end

   ctrl_t            ctrl;
   logic             ud;
   logic [1:0]       pin_vec, fall_vec;
   logic             serial, inc, trig, trig_load, trig_cap;
   logic             ovf, ovf_q, ctrl_we, mode_we;
   logic [NB-1:0]    cnt_we, rld_we;
   logic [CNT_W-1:0] cnt, rld, cap;

   // pin 0: count source, pin 1: trigger
   assign pin_vec = {trig_pin_i, cnt_pin_i};

   for (genvar p = 0; p < 2; p++) begin : g_pin
      crt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .pin_i  (pin_vec[p]),
         .fall_o (fall_vec[p])
      );
   end

   assign serial    = ctrl.rx_sel | ctrl.tx_sel;
   assign inc       = ctrl.run & (ctrl.src_pin ? fall_vec[0] : tick_i);
   assign trig      = fall_vec[1] & ctrl.ext_en & ~serial;
   assign trig_load = trig & ~ctrl.cap_sel;
   assign trig_cap  = trig & ctrl.cap_sel;

   assign ctrl_we = wr_en_i & (addr_i == ADDR_W'(REG_CTRL));
   assign mode_we = wr_en_i & (addr_i == ADDR_W'(REG_MODE));

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign cnt_we[b] = wr_en_i & (addr_i == ADDR_W'(REG_CNT + b));
      assign rld_we[b] = wr_en_i & (addr_i == ADDR_W'(RLD_BASE + b));
   end

   crt_counter #(.W(CNT_W)) u_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .inc_i       (inc),
      .trig_load_i (trig_load),
      .trig_cap_i  (trig_cap),
      .ovf_load_i  (serial | ~ctrl.cap_sel),
      .cnt_we_i    (cnt_we),
      .rld_we_i    (rld_we),
      .wbyte_i     (wdata_i),
      .cnt_o       (cnt),
      .rld_o       (rld),
      .cap_o       (cap),
      .ovf_o       (ovf)
   );

   crt_ctrl u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_we_i (ctrl_we),
      .mode_we_i (mode_we),
      .wbyte_i   (wdata_i),
      .set_ovf_i (ovf & ~serial),
      .set_ext_i (trig),
      .ctrl_o    (ctrl),
      .ud_o      (ud),
      .irq_o     (irq_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ovf_q <= 1'b0;
      else         ovf_q <= ovf;
   end

   assign rx_baud_o = ctrl.rx_sel ? ovf_q : alt_rx_tick_i;
   assign tx_baud_o = ctrl.tx_sel ? ovf_q : alt_tx_tick_i;

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(REG_CTRL)) rdata_o = ctrl;
      if (addr_i == ADDR_W'(REG_MODE)) rdata_o = {7'b0, ud};
      for (int b = 0; b < NB; b++) begin
         if (addr_i == ADDR_W'(REG_CNT + b))  rdata_o = cnt[b*8 +: 8];
         if (addr_i == ADDR_W'(RLD_BASE + b)) rdata_o = rld[b*8 +: 8];
         if (addr_i == ADDR_W'(CAP_BASE + b)) rdata_o = cap[b*8 +: 8];
      end
   end

endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
   parameter int unsigned W = 16
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         run_i,
   input logic         serial_i,
   input logic         ext_en_i,
   input logic         rx_sel_i,
   input logic         ovf_flag_i,
   input logic         ext_flag_i,
   input logic         ud_i,
   input logic         ctrl_we_i,
   input logic         cnt_we_i,
   input logic         trig_load_i,
   input logic         rx_baud_i,
   input logic         irq_i,
   input logic [W-1:0] cnt_i,
   input logic [W-1:0] cap_i
);

   assert_run_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !cnt_we_i && !trig_load_i) |=> (cnt_i == $past(cnt_i)));

   assert_ovf_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(ovf_flag_i) && !$past(ctrl_we_i)) |-> $past(!serial_i));

   assert_ext_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(ext_flag_i) && !$past(ctrl_we_i)) |-> $past(ext_en_i && !serial_i));

   assert_no_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      serial_i |=> $stable(cap_i));

   assert_baud_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_sel_i && rx_baud_i) |-> ($past(cnt_i) == {W{1'b1}} && $past(run_i)));

   assert_irq_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ud_i && !ovf_flag_i) |-> !irq_i);

endmodule

bind cr_timer crt_checker #(.W(CNT_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .run_i       (ctrl.run),
   .serial_i    (serial),
   .ext_en_i    (ctrl.ext_en),
   .rx_sel_i    (ctrl.rx_sel),
   .ovf_flag_i  (ctrl.ovf_flag),
   .ext_flag_i  (ctrl.ext_flag),
   .ud_i        (ud),
   .ctrl_we_i   (ctrl_we),
   .cnt_we_i    (|cnt_we),
   .trig_load_i (trig_load),
   .rx_baud_i   (rx_baud_o),
   .irq_i       (irq_o),
   .cnt_i       (cnt),
   .cap_i       (cap)
);

// File: tb/tb_cr_timer.sv
module tb_cr_timer;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1;
   logic       alt_rx = 1'b0, alt_tx = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq, rxb, txb;

   int    nchk = 0, nerr = 0;
   bit    done = 1'b0;
   string ph = "R1";

   // behavioural reference state
   logic [15:0] m_cnt, m_rld, m_cap;
   logic [7:0]  m_ctrl;
   logic        m_ud, m_ovfq;
   bit          tq[$];
   bit          cq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cr_timer dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cnt_pin_i(cnt_pin),
      .trig_pin_i(trig_pin), .alt_rx_tick_i(alt_rx), .alt_tx_tick_i(alt_tx),
      .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
      .irq_o(irq), .rx_baud_o(rxb), .tx_baud_o(txb)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input logic [2:0] a);
      case (a)
         3'd0: return m_ctrl;
         3'd1: return {7'b0, m_ud};
         3'd2: return m_cnt[7:0];
         3'd3: return m_cnt[15:8];
         3'd4: return m_rld[7:0];
         3'd5: return m_rld[15:8];
         3'd6: return m_cap[7:0];
         default: return m_cap[15:8];
      endcase
   endfunction

   // model advances on each rising edge from the inputs driven half a cycle earlier
   always @(posedge clk) begin : model
      bit te, ce, ser, inc, trg, ovf;
      logic [7:0] c;
      if (!rst_n) begin
         m_cnt = 0; m_rld = 0; m_cap = 0; m_ctrl = 0; m_ud = 0; m_ovfq = 0;
         tq = '{1'b0, 1'b0, 1'b0};
         cq = '{1'b0, 1'b0, 1'b0};
      end else begin
         c   = m_ctrl;
         te  = tq[2] && !tq[1];
         ce  = cq[2] && !cq[1];
         tq.push_front(trig_pin); void'(tq.pop_back());
         cq.push_front(cnt_pin);  void'(cq.pop_back());
         ser = c[4] || c[5];
         inc = c[0] && (c[1] ? ce : tick);
         trg = te && c[3] && !ser;
         ovf = inc && (m_cnt == 16'hFFFF);
         if (trg && c[2]) m_cap = m_cnt;
         if (trg && !c[2])  m_cnt = m_rld;
         else if (ovf)      m_cnt = (ser || !c[2]) ? m_rld : 16'h0000;
         else if (inc)      m_cnt = m_cnt + 16'd1;
         if (wr_en) begin
            case (addr)
               3'd0: m_ctrl = wdata;
               3'd1: m_ud = wdata[0];
               3'd2: m_cnt[7:0] = wdata;
               3'd3: m_cnt[15:8] = wdata;
               3'd4: m_rld[7:0] = wdata;
               3'd5: m_rld[15:8] = wdata;
               default: ;
            endcase
         end
         if (ovf && !ser) m_ctrl[6] = 1'b1;
         if (trg)         m_ctrl[7] = 1'b1;
         m_ovfq = ovf;
      end
   end

   // per-cycle comparison, away from both edges
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk("R10 irq", {15'b0, irq}, {15'b0, m_ctrl[6] | (m_ctrl[7] & ~m_ud)});
         chk("R9 rx_baud", {15'b0, rxb}, {15'b0, m_ctrl[4] ? m_ovfq : alt_rx});
         chk("R9 tx_baud", {15'b0, txb}, {15'b0, m_ctrl[5] ? m_ovfq : alt_tx});
         chk({ph, " rdata"}, {8'b0, rdata}, {8'b0, exp_rd(addr)});
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic wr16(input logic [2:0] a, input logic [15:0] v);
      wr(a, v[7:0]); wr(a + 3'd1, v[15:8]);
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk); addr = a; #1;
      chk(tag, {8'b0, rdata}, {8'b0, exp});
   endtask

   task automatic rd16(input logic [2:0] a, input logic [15:0] exp, input string tag);
      rd(a, exp[7:0], tag); rd(a + 3'd1, exp[15:8], tag);
   endtask

   task automatic pulse(input int n);
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic trig_fall();
      @(negedge clk); trig_pin = 1'b0;
      repeat (4) @(negedge clk); trig_pin = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic cnt_fall();
      @(negedge clk); cnt_pin = 1'b0;
      repeat (3) @(negedge clk); cnt_pin = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      ph = "R1";
      for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1 reset readback");
      chk("R1 irq at reset", {15'b0, irq}, 16'h0);

      // R4 R5 R12: reload on overflow, flag set and cleared
      ph = "R12";
      wr16(3'd4, 16'h1234);
      wr16(3'd2, 16'hFFFE);
      rd16(3'd4, 16'h1234, "R12 reload readback");
      wr(3'd0, 8'h01);
      ph = "R4";
      pulse(2);
      rd16(3'd2, 16'h1234, "R4 reload on overflow");
      rd(3'd0, 8'h41, "R5 overflow flag set");
      chk("R10 irq from overflow flag", {15'b0, irq}, 16'h1);
      wr(3'd0, 8'h01);
      rd(3'd0, 8'h01, "R5 software clear");
      chk("R10 irq cleared", {15'b0, irq}, 16'h0);

      // R2: run bit off holds the counter
      ph = "R2";
      wr(3'd0, 8'h00);
      pulse(5);
      rd16(3'd2, 16'h1234, "R2 hold while stopped");

      // R3: pin source ignores tick, counts pin falls
      ph = "R3";
      wr(3'd0, 8'h03);
      pulse(5);
      rd16(3'd2, 16'h1234, "R3 tick ignored in pin mode");
      for (int i = 0; i < 3; i++) cnt_fall();
      repeat (4) @(negedge clk);
      rd16(3'd2, 16'h1237, "R3 pin falls counted");

      // R7 R4: capture mode
      ph = "R7";
      wr(3'd0, 8'h00);
      wr16(3'd2, 16'h0100);
      wr(3'd0, 8'h0D);
      trig_fall();
      rd16(3'd6, 16'h0100, "R7 capture value");
      rd(3'd0, 8'h8D, "R7 trigger flag");
      pulse(3);
      rd16(3'd2, 16'h0103, "R7 counting continues");
      wr16(3'd2, 16'hFFFF);
      pulse(1);
      rd16(3'd2, 16'h0000, "R4 wrap in capture mode");
      rd(3'd0, 8'hCD, "R5 flag in capture mode");

      // R6: trigger reload, and trigger disabled
      ph = "R6";
      wr(3'd0, 8'h09);
      wr16(3'd2, 16'h0050);
      trig_fall();
      rd16(3'd2, 16'h1234, "R6 trigger reload");
      rd(3'd0, 8'h89, "R6 trigger flag");
      wr(3'd0, 8'h01);
      wr16(3'd2, 16'h0050);
      trig_fall();
      rd16(3'd2, 16'h0050, "R6 trigger ignored when disabled");
      rd(3'd0, 8'h01, "R6 no flag when disabled");

      // R8 R9: serial clock mode
      ph = "R8";
      wr(3'd0, 8'h1D);
      wr16(3'd2, 16'hFFFE);
      trig_fall();
      rd16(3'd6, 16'h0100, "R8 no capture in serial mode");
      rd(3'd0, 8'h1D, "R8 no trigger flag in serial mode");
      pulse(2);
      #1;
      chk("R9 rx pulse after overflow", {15'b0, rxb}, 16'h1);
      chk("R9 tx follows alt tick", {15'b0, txb}, 16'h0);
      @(negedge clk); #1;
      chk("R9 rx pulse one cycle", {15'b0, rxb}, 16'h0);
      rd16(3'd2, 16'h1234, "R8 forced reload");
      rd(3'd0, 8'h1D, "R5 no overflow flag in serial mode");
      chk("R8 irq quiet", {15'b0, irq}, 16'h0);
      wr(3'd0, 8'h21);
      wr16(3'd2, 16'hFFFF);
      pulse(1);
      #1;
      chk("R9 tx pulse after overflow", {15'b0, txb}, 16'h1);
      chk("R9 rx follows alt tick", {15'b0, rxb}, 16'h0);
      wr(3'd0, 8'h01);
      @(negedge clk); alt_rx = 1'b1; #1;
      chk("R9 alt rx passes", {15'b0, rxb}, 16'h1);
      @(negedge clk); alt_rx = 1'b0;

      // R10: option bit masks the trigger flag
      ph = "R10";
      wr(3'd0, 8'h09);
      wr(3'd1, 8'h01);
      rd(3'd1, 8'h01, "R12 option readback");
      trig_fall();
      rd(3'd0, 8'h89, "R10 flag still set");
      chk("R10 irq masked", {15'b0, irq}, 16'h0);
      wr(3'd1, 8'h00);
      @(negedge clk); #1;
      chk("R10 irq unmasked", {15'b0, irq}, 16'h1);

      // R5: hardware set beats software clear in the same cycle
      ph = "R5";
      wr(3'd0, 8'h01);
      wr16(3'd2, 16'hFFFF);
      @(negedge clk); wr_en = 1'b1; addr = 3'd0; wdata = 8'h01; tick = 1'b1;
      @(negedge clk); wr_en = 1'b0; tick = 1'b0;
      rd(3'd0, 8'h41, "R5 set wins over clear");

      // R12: byte write beats increment
      ph = "R12";
      wr16(3'd2, 16'hFFF0);
      @(negedge clk); wr_en = 1'b1; addr = 3'd2; wdata = 8'h00; tick = 1'b1;
      @(negedge clk); wr_en = 1'b0; tick = 1'b0;
      rd16(3'd2, 16'hFF00, "R12 write wins");

      // R11: edge timing and single event
      ph = "R11";
      wr(3'd0, 8'h0D);
      wr16(3'd2, 16'h0777);
      addr = 3'd0;
      @(negedge clk); trig_pin = 1'b0;
      @(negedge clk);
      @(negedge clk); #1;
      chk("R11 not yet at second edge", {8'b0, rdata}, 16'h000D);
      @(negedge clk); #1;
      chk("R11 event at third edge", {8'b0, rdata}, 16'h008D);
      repeat (10) @(negedge clk);
      wr(3'd0, 8'h0D);
      wr16(3'd2, 16'h0888);
      repeat (5) @(negedge clk);
      rd(3'd0, 8'h0D, "R11 held low gives one event");
      rd16(3'd6, 16'h0777, "R11 captured once");
      trig_pin = 1'b1;
      repeat (5) @(negedge clk);
      rd(3'd0, 8'h0D, "R11 rising edge ignored");

      // mixed stimulus
      ph = "R12";
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         tick   = 1'($urandom % 2);
         alt_rx = 1'($urandom % 2);
         alt_tx = 1'($urandom % 2);
         wr_en  = ($urandom % 6 == 0);
         addr   = 3'($urandom % 8);
         wdata  = 8'($urandom);
         if ($urandom % 8 == 0) trig_pin = ~trig_pin;
         if ($urandom % 5 == 0) cnt_pin = ~cnt_pin;
      end
      @(negedge clk); wr_en = 1'b0;
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule